// File: doc/BRIEF.md
# Monitor Command Decoder and Channel Sequencer

This block sits behind the byte-level receiver of a two-wire host bus on a small multichannel acquisition monitor. It takes the first byte the host sends after a start condition and decodes it. The upper nibble is a device identifier. The rest of the byte holds an operation select, a channel field and a read/monitor bit. From these fields the block starts one of four activities:

- a bus-timed conversion read, which the host may repeat on one channel or step across all channels;
- a self-timed autonomous monitor of one channel or all channels;
- a read of one channel's window limits;
- a write of one channel's window limits.

The block drives the analog multiplexer select, a sample/hold acquire level and a one-cycle convert start. Each 10-bit result is compared against the current channel's lower and upper limits. A result outside its window raises a sticky active-low alert.

A bus-timed acquisition opens in the cycle after the command is accepted, which covers the acknowledge slot. It closes when the receiver reports the next rising bus clock (`scl_rise`). In monitor mode the block times the acquisition itself, for `ACQ_CYC` cycles.

The sequencer has six states:

- `S_IDLE` moves to `S_ACQ_BUS` on a valid read command, or to `S_ACQ_SELF` on a valid monitor command.
- `S_ACQ_BUS` moves to `S_START` on `scl_rise`.
- `S_ACQ_SELF` moves to `S_START` after `ACQ_CYC` cycles.
- `S_START` always moves to `S_CONV` after one cycle.
- `S_CONV` moves on `conv_done`: to `S_HOLD` in read mode, or back to `S_ACQ_SELF` in monitor mode.
- `S_HOLD` moves to `S_ACQ_BUS` on `rd_more`.
- Any state other than `S_IDLE` returns to `S_IDLE` on `stop`, and `stop` has priority over every other transition.

Top module: `mon_cmd_seq`

## Requirements
- R1: After reset: the sequencer is idle; `acquire`, `conv_start` and `rd_valid` are 0; `mux_sel` is 0; `alert_n` is 1; every channel's lower limit is 0 and its upper limit is 1023.
- R2: Command byte bits 7:4 must equal 1001 when `ADDRESSABLE`=0, or {`addr_pins`,1} when `ADDRESSABLE`=1. A byte with any other identifier leaves the state, `mux_sel`, the limits and `alert_n` unchanged, and produces no `rd_valid`.
- R3: Bit 3 = 0 selects a conversion and bit 3 = 1 selects a limit operation. Channel field bits 2:1 = 00, 01 or 10 select channel 0, 1 or 2, and `mux_sel` shows that channel from the cycle after acceptance. Field 11 with bit 3 = 1 is invalid and is ignored.
- R4: In a read conversion (bit 0 = 1), `acquire` is 1 from the cycle after the command until the cycle in which `scl_rise` is sampled. `conv_start` is 1 for exactly the one following cycle, and `acquire` is 0 during that cycle.
- R5: In read mode, a `conv_done` sampled while converting sets `rd_data` to `conv_data` and `rd_upper` to 0 in the next cycle, with a one-cycle `rd_valid` pulse.
- R6: After a read result, `rd_more` starts a new bus-timed acquisition. It uses the same channel for a fixed channel. Under auto-increment it uses the next channel, wrapping from channel NCH-1 to channel 0.
- R7: Auto-increment (field 11, bit 3 = 0) always starts at channel 0.
- R8: Monitor mode (bit 3 = 0, bit 0 = 0) holds `acquire` for exactly `ACQ_CYC` cycles, then pulses `conv_start`. After each `conv_done` it starts the next acquisition, stepping the channel under auto-increment, until `stop` arrives. Monitor results do not update `rd_data`.
- R9: Bit 3 = 1 with bit 0 = 0 writes `lim_wr_lo` and `lim_wr_hi` as the channel's lower and upper limits. Bit 3 = 1 with bit 0 = 1 returns the lower limit on `rd_data` and the upper limit on `rd_upper` in the next cycle, with `rd_valid` = 1.
- R10: A captured result below the channel's lower limit or above its upper limit drives `alert_n` to 0 in the next cycle. A result equal to either limit does not.
- R11: `alert_n` stays 0 until an `alert_clr` pulse, which returns it to 1 in the next cycle. If a new out-of-window result arrives in the same cycle as `alert_clr`, `alert_n` stays 0.
- R12: `stop` returns any busy state to idle in the next cycle, so `acquire` and `conv_start` are 0. A `conv_done` that arrives in the same cycle as `stop` is discarded: it produces no alarm and no `rd_valid`.
- R13: A command byte that arrives while the sequencer is busy is ignored, and `mux_sel` keeps its value.
- R14: With `NCH`=2, field 10 is invalid and starts nothing, and auto-increment wraps from channel 1 to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| addr_pins | input | 3 | strap pins forming bits 7:5 of the identifier on the addressable build |
| cmd_valid | input | 1 | one-cycle strobe: `cmd_byte` holds a freshly received first byte |
| cmd_byte | input | 8 | command byte |
| lim_wr_lo | input | 10 | lower limit value for a limit write |
| lim_wr_hi | input | 10 | upper limit value for a limit write |
| scl_rise | input | 1 | rising bus clock that follows an acknowledge slot |
| rd_more | input | 1 | host acknowledged a result and wants another one |
| stop | input | 1 | bus stop condition |
| conv_done | input | 1 | converter finished; `conv_data` is valid |
| conv_data | input | 10 | converter result |
| alert_clr | input | 1 | host clears the alert |
| mux_sel | output | 2 | analog multiplexer channel |
| acquire | output | 1 | sample/hold tracking |
| conv_start | output | 1 | one-cycle convert request |
| rd_valid | output | 1 | one-cycle pulse: read data updated |
| rd_data | output | 10 | conversion result or lower limit |
| rd_upper | output | 10 | upper limit on limit reads, 0 on conversion reads |
| alert_n | output | 1 | active-low window alarm |

## Verification
Two functions can land in the same cycle: setting the window alarm from a fresh out-of-window result, and clearing it on `alert_clr`. The bench provokes this by raising `alert_clr` in the cycle that `conv_done` carries a value below the lower limit. It then expects `alert_n` to stay low, and to rise only after a later clear that comes alone. A second collision puts `stop` in the same cycle as `conv_done` with an out-of-range value. In that case the reference model expects the result to be dropped, with no alarm and no `rd_valid`. A behavioural model tracks every output on every cycle through all of these cases.

// File: rtl/mon_pkg.sv
package mon_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACQ_BUS,
        S_ACQ_SELF,
        S_START,
        S_CONV,
        S_HOLD
    } seq_state_t;

    typedef struct packed {
        logic       valid;
        logic       lim_op;
        logic       rd;
        logic       auto_inc;
        logic [1:0] ch;
    } cmd_t;

endpackage

// File: rtl/mon_cmd_decode.sv
module mon_cmd_decode
    import mon_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int ADDRESSABLE = 0
) (
    input  logic [7:0] cmd_byte,
    input  logic [2:0] addr_pins,
    output cmd_t       dec
);

    logic [3:0] want_id;
    logic [1:0] fld;
    logic       id_ok;

    always_comb begin
        want_id      = (ADDRESSABLE != 0) ? {addr_pins, 1'b1} : 4'b1001;
        fld          = cmd_byte[2:1];
        id_ok        = (cmd_byte[7:4] == want_id);
        dec.lim_op   = cmd_byte[3];
        dec.rd       = cmd_byte[0];
        dec.ch       = fld;
        dec.auto_inc = (fld == 2'b11) && !cmd_byte[3];
        dec.valid    = id_ok && (dec.auto_inc || (int'(fld) < NCH));
    end

endmodule

// File: rtl/mon_chan_seq.sv
module mon_chan_seq #(
    parameter int NCH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       load_auto,
    input  logic [1:0] load_ch,
    input  logic       advance,
    output logic [1:0] chan
);

    localparam logic [1:0] LAST = 2'(NCH - 1);

    logic auto_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan   <= 2'd0;
            auto_q <= 1'b0;
        end else if (load) begin
            auto_q <= load_auto;
            chan   <= load_auto ? 2'd0 : load_ch;
        end else if (advance && auto_q) begin
            chan <= (chan == LAST) ? 2'd0 : chan + 2'd1;
        end
    end

    // R6: the step after the last channel lands on channel 0
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && auto_q && !load && chan == LAST) |=> (chan == 2'd0));

    // R6: a fixed channel is kept across repeats
    a_r6_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !auto_q && !load) |=> $stable(chan));

    // R3: the selected channel always exists
    a_r3_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan) < NCH);

endmodule

// File: rtl/mon_limit_bank.sv
module mon_limit_bank #(
    parameter int NCH   = 3,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_ch,
    input  logic [RES_W-1:0] wr_lo,
    input  logic [RES_W-1:0] wr_hi,
    input  logic [1:0]       rd_ch,
    output logic [RES_W-1:0] rd_lo,
    output logic [RES_W-1:0] rd_hi,
    input  logic             cmp_en,
    input  logic [1:0]       cmp_ch,
    input  logic [RES_W-1:0] cmp_val,
    input  logic             alert_clr,
    output logic             alert_n
);

    logic [RES_W-1:0] lo_q [NCH];
    logic [RES_W-1:0] hi_q [NCH];
    logic [RES_W-1:0] cmp_lo, cmp_hi;
    logic             outside;
    logic             alert_q;

    for (genvar i = 0; i < NCH; i++) begin : g_lim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[i] <= '0;
                hi_q[i] <= '1;
            end else if (wr_en && int'(wr_ch) == i) begin
                lo_q[i] <= wr_lo;
                hi_q[i] <= wr_hi;
            end
        end
    end

    always_comb begin
        rd_lo  = '0;
        rd_hi  = '0;
        cmp_lo = '0;
        cmp_hi = '1;
        for (int i = 0; i < NCH; i++) begin
            if (int'(rd_ch) == i) begin
                rd_lo = lo_q[i];
                rd_hi = hi_q[i];
            end
            if (int'(cmp_ch) == i) begin
                cmp_lo = lo_q[i];
                cmp_hi = hi_q[i];
            end
        end
        outside = (cmp_val < cmp_lo) || (cmp_val > cmp_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 alert_q <= 1'b0;
        else if (cmp_en && outside) alert_q <= 1'b1;
        else if (alert_clr)         alert_q <= 1'b0;
    end

    assign alert_n = !alert_q;

    // R11: the alarm holds until a clear arrives
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_n && !alert_clr) |=> !alert_n);

    // R11: a clear with no new result releases the alarm
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_clr && !cmp_en) |=> alert_n);

    // R10: a result on or inside the limits raises nothing
    a_r10_inside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_n && cmp_en && cmp_val >= cmp_lo && cmp_val <= cmp_hi) |=> alert_n);

endmodule

// File: rtl/mon_cmd_seq.sv
module mon_cmd_seq
    import mon_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int ADDRESSABLE = 0,
    parameter int RES_W       = 10,
    parameter int ACQ_CYC     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr_pins,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic [RES_W-1:0] lim_wr_lo,
    input  logic [RES_W-1:0] lim_wr_hi,
    input  logic             scl_rise,
    input  logic             rd_more,
    input  logic             stop,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             alert_clr,
    output logic [1:0]       mux_sel,
    output logic             acquire,
    output logic             conv_start,
    output logic             rd_valid,
    output logic [RES_W-1:0] rd_data,
    output logic [RES_W-1:0] rd_upper,
    output logic             alert_n
);

    localparam int CNT_W = $clog2(ACQ_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACQ_CYC - 1);

    seq_state_t       st, st_n;
    cmd_t             dec;
    logic             rd_q;
    logic [CNT_W-1:0] cnt;
    logic             take_cmd, seq_load, lim_wr, lim_rd;
    logic             capture, advance;
    logic [RES_W-1:0] lim_lo, lim_hi;

    mon_cmd_decode #(.NCH(NCH), .ADDRESSABLE(ADDRESSABLE)) u_dec (
        .cmd_byte (cmd_byte),
        .addr_pins(addr_pins),
        .dec      (dec)
    );

    always_comb begin
        take_cmd = (st == S_IDLE) && cmd_valid && dec.valid;
        seq_load = take_cmd && !dec.lim_op;
        lim_wr   = take_cmd && dec.lim_op && !dec.rd;
        lim_rd   = take_cmd && dec.lim_op && dec.rd;
        capture  = (st == S_CONV) && conv_done && !stop;
        advance  = (capture && !rd_q) || ((st == S_HOLD) && rd_more && !stop);
    end

    mon_chan_seq #(.NCH(NCH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .load_auto(dec.auto_inc),
        .load_ch  (dec.ch),
        .advance  (advance),
        .chan     (mux_sel)
    );

    mon_limit_bank #(.NCH(NCH), .RES_W(RES_W)) u_lim (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lim_wr),
        .wr_ch    (dec.ch),
        .wr_lo    (lim_wr_lo),
        .wr_hi    (lim_wr_hi),
        .rd_ch    (dec.ch),
        .rd_lo    (lim_lo),
        .rd_hi    (lim_hi),
        .cmp_en   (capture),
        .cmp_ch   (mux_sel),
        .cmp_val  (conv_data),
        .alert_clr(alert_clr),
        .alert_n  (alert_n)
    );

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:     if (seq_load) st_n = dec.rd ? S_ACQ_BUS : S_ACQ_SELF;
            S_ACQ_BUS:  if (scl_rise) st_n = S_START;
            S_ACQ_SELF: if (cnt == CNT_LAST) st_n = S_START;
            S_START:    st_n = S_CONV;
            S_CONV:     if (conv_done) st_n = rd_q ? S_HOLD : S_ACQ_SELF;
            S_HOLD:     if (rd_more) st_n = S_ACQ_BUS;
            default:    st_n = S_IDLE;
        endcase
        if (st != S_IDLE && stop) st_n = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // mode flag and self-timed acquisition counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            cnt  <= '0;
        end else begin
            if (seq_load) rd_q <= dec.rd;
            if (st != S_ACQ_SELF) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end
    end

    // read-back registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_upper <= '0;
        end else begin
            rd_valid <= lim_rd || (capture && rd_q);
            if (lim_rd) begin
                rd_data  <= lim_lo;
                rd_upper <= lim_hi;
            end else if (capture && rd_q) begin
                rd_data  <= conv_data;
                rd_upper <= '0;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        acquire    = 1'b0;
        conv_start = 1'b0;
        unique case (st)
            S_ACQ_BUS, S_ACQ_SELF: acquire = 1'b1;
            S_START:               conv_start = 1'b1;
            default: ;
        endcase
    end

    // R4: the convert request lasts one cycle
    a_r4_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4: a convert request always follows an acquisition
    a_r4_start_after_acq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) |-> $past(acquire));

    // R12: stop silences acquisition and conversion requests
    a_r12_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && (acquire || conv_start)) |=> (!acquire && !conv_start));

    // R2: a rejected byte leaves the sequencer idle on the same channel
    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && cmd_valid && !dec.valid) |=> (st == S_IDLE && $stable(mux_sel)));

    // R13: a byte arriving mid-transfer changes nothing
    a_r13_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HOLD && cmd_valid && !rd_more && !stop) |=> ($stable(mux_sel) && !acquire));

endmodule

// File: tb/mon_cmd_seq_test.sv
module mon_cmd_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr_pins = 3'b100;
    logic       cmd_valid = 0, scl_rise = 0, rd_more = 0, stop = 0;
    logic       conv_done = 0, alert_clr = 0;
    logic [7:0] cmd_byte = 0;
    logic [9:0] lim_wr_lo = 0, lim_wr_hi = 0, conv_data = 0;
    logic [1:0] mux_sel, mux_sel2;
    logic       acquire, conv_start, rd_valid, alert_n;
    logic       acquire2, conv_start2, rd_valid2, alert_n2;
    logic [9:0] rd_data, rd_upper, rd_data2, rd_upper2;

    int vectors = 0, miscompares = 0, cyc = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    mon_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .cmd_valid(cmd_valid),
        .cmd_byte(cmd_byte), .lim_wr_lo(lim_wr_lo), .lim_wr_hi(lim_wr_hi),
        .scl_rise(scl_rise), .rd_more(rd_more), .stop(stop), .conv_done(conv_done),
        .conv_data(conv_data), .alert_clr(alert_clr), .mux_sel(mux_sel),
        .acquire(acquire), .conv_start(conv_start), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_upper(rd_upper), .alert_n(alert_n)
    );

    mon_cmd_seq #(.NCH(2), .ADDRESSABLE(1)) uut2 (
        .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .cmd_valid(cmd_valid),
        .cmd_byte(cmd_byte), .lim_wr_lo(lim_wr_lo), .lim_wr_hi(lim_wr_hi),
        .scl_rise(scl_rise), .rd_more(rd_more), .stop(stop), .conv_done(conv_done),
        .conv_data(conv_data), .alert_clr(alert_clr), .mux_sel(mux_sel2),
        .acquire(acquire2), .conv_start(conv_start2), .rd_valid(rd_valid2),
        .rd_data(rd_data2), .rd_upper(rd_upper2), .alert_n(alert_n2)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // behavioural reference of the default build (3 channels, fixed id, 4-cycle self acquisition)
    int  m_phase = 0;   // 0 idle, 1 bus acquire, 2 self acquire, 3 start, 4 convert, 5 hold
    int  m_ch = 0, m_cnt = 0, m_rdd = 0, m_rdu = 0;
    bit  m_auto = 0, m_rd = 0, m_rdv = 0, m_alert = 0;
    int  m_lo[3] = '{0, 0, 0};
    int  m_hi[3] = '{1023, 1023, 1023};

    always @(posedge clk) begin
        int f;
        bit set;
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_ch = 0; m_cnt = 0; m_rdd = 0; m_rdu = 0;
            m_auto = 0; m_rd = 0; m_rdv = 0; m_alert = 0;
            for (int i = 0; i < 3; i++) begin m_lo[i] = 0; m_hi[i] = 1023; end
        end else begin
            m_rdv = 0;
            set = 0;
            f = int'(cmd_byte[2:1]);
            if (m_phase != 0 && stop) m_phase = 0;
            else case (m_phase)
                0: if (cmd_valid && cmd_byte[7:4] == 4'b1001 &&
                       (f < 3 || (f == 3 && !cmd_byte[3]))) begin
                    if (cmd_byte[3]) begin
                        if (cmd_byte[0]) begin
                            m_rdv = 1; m_rdd = m_lo[f]; m_rdu = m_hi[f];
                        end else begin
                            m_lo[f] = int'(lim_wr_lo); m_hi[f] = int'(lim_wr_hi);
                        end
                    end else begin
                        m_auto = (f == 3);
                        m_ch = m_auto ? 0 : f;
                        m_rd = cmd_byte[0];
                        m_phase = m_rd ? 1 : 2;
                        m_cnt = 0;
                    end
                end
                1: if (scl_rise) m_phase = 3;
                2: begin
                    m_cnt++;
                    if (m_cnt == 4) m_phase = 3;
                end
                3: m_phase = 4;
                4: if (conv_done) begin
                    if (int'(conv_data) < m_lo[m_ch] || int'(conv_data) > m_hi[m_ch]) set = 1;
                    if (m_rd) begin
                        m_rdv = 1; m_rdd = int'(conv_data); m_rdu = 0; m_phase = 5;
                    end else begin
                        if (m_auto) m_ch = (m_ch + 1) % 3;
                        m_phase = 2; m_cnt = 0;
                    end
                end
                5: if (rd_more) begin
                    if (m_auto) m_ch = (m_ch + 1) % 3;
                    m_phase = 1;
                end
                default: m_phase = 0;
            endcase
            if (set) m_alert = 1;
            else if (alert_clr) m_alert = 0;
        end
        if (cyc > 20000) begin
            vectors++; miscompares++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 acquire", int'(acquire), int'(m_phase == 1 || m_phase == 2));
            chk("R4 conv_start", int'(conv_start), int'(m_phase == 3));
            chk("R3 mux_sel", int'(mux_sel), m_ch);
            chk("R10 alert_n", int'(alert_n), int'(!m_alert));
            chk("R5 rd_valid", int'(rd_valid), int'(m_rdv));
            chk("R5 rd_data", int'(rd_data), m_rdd);
            chk("R9 rd_upper", int'(rd_upper), m_rdu);
        end
    end

    task automatic step(); @(negedge clk); endtask

    task automatic send(input logic [7:0] b);
        step(); cmd_valid = 1; cmd_byte = b;
        step(); cmd_valid = 0;
    endtask

    task automatic bus_conv(input logic [9:0] d, input bit clr);
        step();
        step(); scl_rise = 1;
        step(); scl_rise = 0;
        step(); conv_done = 1; conv_data = d; alert_clr = clr;
        step(); conv_done = 0; alert_clr = 0;
    endtask

    task automatic more();
        step(); rd_more = 1;
        step(); rd_more = 0;
    endtask

    task automatic halt();
        step(); stop = 1;
        step(); stop = 0;
    endtask

    task automatic clr_alert();
        step(); alert_clr = 1;
        step(); alert_clr = 0;
    endtask

    task automatic mon_conv(input logic [9:0] d);
        while (!conv_start) step();
        step(); conv_done = 1; conv_data = d;
        step(); conv_done = 0;
    endtask

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 alert_n", int'(alert_n), 1);
        chk("R1 acquire", int'(acquire), 0);
        chk("R1 mux_sel", int'(mux_sel), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);

        // R9 default limits, then write and read back
        send(8'b1001_1_01_1);
        chk("R9 default lower", int'(rd_data), 0);
        chk("R9 default upper", int'(rd_upper), 1023);
        lim_wr_lo = 100; lim_wr_hi = 800; send(8'b1001_1_00_0);
        lim_wr_lo = 200; lim_wr_hi = 300; send(8'b1001_1_01_0);
        send(8'b1001_1_00_1);
        chk("R9 readback lower", int'(rd_data), 100);
        chk("R9 readback upper", int'(rd_upper), 800);

        // R3 R4 R5 single read on channel 1
        send(8'b1001_0_01_1);
        chk("R3 channel 1 selected", int'(mux_sel), 1);
        chk("R4 acquiring in ack slot", int'(acquire), 1);
        step();
        step(); scl_rise = 1;
        step(); scl_rise = 0;
        chk("R4 start after rise", int'(conv_start), 1);
        chk("R4 acquire closed", int'(acquire), 0);
        step(); conv_done = 1; conv_data = 250;
        step(); conv_done = 0;
        chk("R5 result", int'(rd_data), 250);
        chk("R5 valid", int'(rd_valid), 1);
        // R6 repeat same channel; R10 boundary then overflow
        more();
        chk("R6 same channel", int'(mux_sel), 1);
        bus_conv(300, 0);
        chk("R10 upper bound inclusive", int'(alert_n), 1);
        more();
        bus_conv(301, 0);
        chk("R10 above upper", int'(alert_n), 0);
        halt();
        repeat (3) step();
        chk("R11 sticky", int'(alert_n), 0);
        clr_alert();
        chk("R11 cleared", int'(alert_n), 1);

        // R11 set and clear in the same cycle
        send(8'b1001_0_01_1);
        bus_conv(150, 1);
        chk("R11 set wins over clear", int'(alert_n), 0);
        halt();
        clr_alert();
        chk("R11 clear alone", int'(alert_n), 1);

        // R7 R6 auto-increment read
        send(8'b1001_0_11_1);
        chk("R7 starts at 0", int'(mux_sel), 0);
        bus_conv(500, 0); more();
        chk("R6 step to 1", int'(mux_sel), 1);
        bus_conv(250, 0); more();
        chk("R6 step to 2", int'(mux_sel), 2);
        bus_conv(10, 0);
        // R13 command while holding is ignored
        send(8'b1001_0_00_1);
        chk("R13 busy ignore mux", int'(mux_sel), 2);
        chk("R13 busy ignore acquire", int'(acquire), 0);
        more();
        chk("R6 wrap to 0", int'(mux_sel), 0);
        halt();

        // R8 monitor channel 0
        send(8'b1001_0_00_0);
        n = 0;
        while (acquire && n < 50) begin n++; step(); end
        chk("R8 self acquisition length", n, 4);
        chk("R8 start after self acquisition", int'(conv_start), 1);
        step(); conv_done = 1; conv_data = 500;
        step(); conv_done = 0;
        chk("R8 next acquisition", int'(acquire), 1);
        chk("R8 monitor leaves read data", int'(rd_data), 10);
        step();
        stop = 1; step(); stop = 0;
        chk("R12 stop mid acquisition", int'(acquire), 0);

        // R8 monitor all channels
        send(8'b1001_0_11_0);
        mon_conv(500);
        chk("R8 monitor steps to 1", int'(mux_sel), 1);
        mon_conv(250);
        mon_conv(0);
        chk("R8 monitor wraps", int'(mux_sel), 0);
        while (!conv_start) step();
        step(); conv_done = 1; conv_data = 900; stop = 1;
        step(); conv_done = 0; stop = 0;
        chk("R12 discarded result no alarm", int'(alert_n), 1);
        chk("R12 idle after stop", int'(acquire), 0);

        // R2 identifier mismatch, R3 invalid field
        send(8'b1000_0_10_1);
        chk("R2 mismatch no acquire", int'(acquire), 0);
        chk("R2 mismatch mux kept", int'(mux_sel), 0);
        send(8'b1001_1_11_1);
        chk("R3 invalid limit field", int'(rd_valid), 0);

        // R14 two-channel addressable build, id 0111
        addr_pins = 3'b011;
        send(8'b0111_0_10_1);
        chk("R14 channel 2 invalid", int'(acquire2), 0);
        chk("R2 other id ignored", int'(acquire), 0);
        send(8'b0111_0_11_1);
        chk("R14 auto starts at 0", int'(mux_sel2), 0);
        chk("R14 acquire", int'(acquire2), 1);
        bus_conv(5, 0); more();
        chk("R14 step to 1", int'(mux_sel2), 1);
        bus_conv(6, 0); more();
        chk("R14 wrap to 0", int'(mux_sel2), 0);
        halt();
        repeat (2) step();
        finish_run();
    end

endmodule